// File: doc/BRIEF.md
# Configuration register bank with interrupt-line routing

This block is a bank of 32-bit system-control configuration registers. It sits behind a word-wide bus with a strobe, a write enable, a 10-bit byte address and separate write and read data. The bus decodes a 1 KiB window. Each register stores only the bits it implements, and each has its own write rule. Some registers are plain read/write. One bit can only be cleared by software. Some bits can only be set by software. One status flag is cleared by writing one to it. Two registers accumulate the ones written to them until reset. An access to an offset that has no register returns zero and leaves the bank unchanged. It also produces a one-cycle error pulse.

Four of the registers hold 4-bit port selectors, one for each of 16 interrupt lines. The routing logic receives the pin levels of up to eight ports. It drives each interrupt line from the pin of the same number on the port that the line's selector names. The actions that the other bits would trigger are not part of this block: memory remapping, firewalling, parity handling and SRAM erase or protection.

Top module: `sysctl_cfg_bank`

## Requirements
- R1: After reset, the register at 0x04 reads 0x7C000001 and every other register reads 0x00000000, so every interrupt line selects port 0.
- R2: Registers sit at byte offsets 0x00 through 0x28 in steps of 4. A read strobe (bus_sel=1, bus_we=0) loads bus_rdata at the next rising edge. bus_rdata holds its value while no read is made.
- R3: An access is undefined when either of two conditions holds: bus_addr[1:0] is not zero, or the word index bus_addr[9:2] is 11 or more. An undefined access changes no register. If it is a read, bus_rdata becomes zero. bus_err is high for exactly the one cycle after the strobe.
- R4: Only the implemented bits are kept. At 0x00 the mask is 0x00000107, at 0x08/0x0C/0x10/0x14 it is 0x0000FFFF, and at 0x24 it is 0x000000FF. Other bits read zero.
- R5: At 0x04, bits in mask 0xFCFF0100 take the written value. Bit 0 is cleared when a zero is written to it. Writing a one leaves bit 0 unchanged, so only reset sets it again. All other bits read zero.
- R6: At 0x1C, bits [3:0] are set by writing one. Writing zero leaves them unchanged, and only reset clears them.
- R7: At 0x1C, bit 8 is set by a pulse on sram_perr_set and cleared by writing one to bit 8. If both happen in the same cycle, the set wins. Writing zero leaves it unchanged.
- R8: At 0x20 and 0x28, every bit written as one is ORed into the register and stays set until reset.
- R9: Offset 0x18 always reads zero, and writes to it have no effect.
- R10: Interrupt line n (0..15) uses the 4-bit selector in the register at 0x08+4*(n/4), bits [(n%4)*4+3:(n%4)*4]. When the selector is g, irq_line[n] equals pin_lvl[g*16+n].
- R11: When a selector value is NPORT (8) or larger, its interrupt line is driven low.
- R12: Routing is combinational. A change of pin level or selector appears on irq_line in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| sram_perr_set | input | 1 | Event pulse that sets the parity status flag |
| pin_lvl | input | 128 | Pin levels, port g pin p at bit g*16+p |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle undefined-access pulse |
| irq_line | output | 16 | Routed interrupt lines |

## Verification
On every cycle the assertions check the following:
- the clear-only firewall bit never rises without reset;
- the lock bits and write-protect bits never fall;
- undefined or unaligned accesses always raise the error pulse and read zero;
- the 0x18 register reads zero;
- the interrupt lines change only when a selector or a pin level changes.

The bench's scenarios have to show the rest, by comparing against a model register file: the exact masks, the reset values, the set-wins priority between the parity event and a clearing write, and the exact port-to-line mapping, including selectors at or above the port count.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int DATA_W   = 32;
  localparam int NREG     = 11;
  localparam int IDX_W    = 4;
  localparam int SEL_W    = 4;
  localparam int LSEL_N   = 4;
  localparam int LINES    = LSEL_N * (16 / SEL_W);

  typedef enum logic [IDX_W-1:0] {
    RG_REMAP  = 4'd0,
    RG_CFG1   = 4'd1,
    RG_LSEL0  = 4'd2,
    RG_LSEL1  = 4'd3,
    RG_LSEL2  = 4'd4,
    RG_LSEL3  = 4'd5,
    RG_SRAMCS = 4'd6,
    RG_CFG2   = 4'd7,
    RG_WP1    = 4'd8,
    RG_KEY    = 4'd9,
    RG_WP2    = 4'd10
  } reg_idx_e;

  localparam logic [DATA_W-1:0] M_REMAP   = 32'h0000_0107;
  localparam logic [DATA_W-1:0] M_CFG1_RW = 32'hFCFF_0100;
  localparam logic [DATA_W-1:0] M_FW_BIT  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] M_LSEL    = 32'h0000_FFFF;
  localparam logic [DATA_W-1:0] M_KEY     = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] M_LOCK    = 32'h0000_000F;
  localparam logic [DATA_W-1:0] M_PEF     = 32'h0000_0100;
  localparam logic [DATA_W-1:0] CFG1_RST  = 32'h7C00_0001;

  function automatic logic [DATA_W-1:0] reset_value(input int idx);
    return (idx == int'(RG_CFG1)) ? CFG1_RST : '0;
  endfunction

  // Next state of register idx given old contents, write strobe/data and the parity event.
  function automatic logic [DATA_W-1:0] reg_next(input int idx,
                                                 input logic [DATA_W-1:0] old,
                                                 input logic wr,
                                                 input logic [DATA_W-1:0] v,
                                                 input logic perr);
    logic [DATA_W-1:0] n;
    n = old;
    if (wr) begin
      case (idx)
        int'(RG_REMAP): n = v & M_REMAP;
        int'(RG_CFG1):  n = (old & v & M_FW_BIT) | (v & M_CFG1_RW);
        int'(RG_LSEL0), int'(RG_LSEL1),
        int'(RG_LSEL2), int'(RG_LSEL3): n = v & M_LSEL;
        int'(RG_CFG2):  n = (old | (v & M_LOCK)) & ~(v & M_PEF);
        int'(RG_WP1), int'(RG_WP2): n = old | v;
        int'(RG_KEY):   n = v & M_KEY;
        default:        n = '0;
      endcase
    end
    if (idx == int'(RG_CFG2) && perr) n = n | M_PEF;
    if (idx == int'(RG_SRAMCS)) n = '0;
    return n;
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_bank_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  output logic [IDX_W-1:0] idx,
  output logic             wr_hit,
  output logic             rd_hit,
  output logic             bad_acc
);
  localparam logic [AW-3:0] IDX_LIMIT = (AW-2)'(NREG);

  logic aligned;
  logic in_map;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_map  = (bus_addr[AW-1:2] < IDX_LIMIT);
  assign idx     = IDX_W'(bus_addr[AW-1:2]);
  assign wr_hit  = bus_sel &  bus_we & aligned & in_map;
  assign rd_hit  = bus_sel & ~bus_we & aligned & in_map;
  assign bad_acc = bus_sel & ~(aligned & in_map);
endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_bank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_hit,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         perr_set,
  output logic [NREG-1:0][DATA_W-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              sel_me;
    assign sel_me = wr_hit && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) q <= reset_value(i);
      else        q <= reg_next(i, q, sel_me, wdata, perr_set);
    end
    assign regs[i] = q;
  end
endmodule

// File: rtl/line_router.sv
module line_router
  import cfg_bank_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic [NPORT*LINES-1:0] pin_lvl,
  input  logic [LINES*SEL_W-1:0] sel_flat,
  output logic [LINES-1:0]       irq_line
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] fld;
    logic             lvl;
    assign fld = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      lvl = 1'b0;
      for (int g = 0; g < NPORT; g++)
        if (fld == SEL_W'(g)) lvl = pin_lvl[g*LINES + n];
    end
    assign irq_line[n] = lvl;
  end
endmodule

// File: rtl/sysctl_cfg_bank.sv
module sysctl_cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NPORT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   sram_perr_set,
  input  logic [NPORT*LINES-1:0] pin_lvl,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_err,
  output logic [LINES-1:0]       irq_line
);
  logic [IDX_W-1:0]            idx;
  logic                        wr_hit, rd_hit, bad_acc;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           rd_val;
  logic [LINES*SEL_W-1:0]      lsel_flat;
  logic [DATA_W-1:0]           cfg1_q, cfg2_q, wp1_q, wp2_q;

  cfg_addr_decode #(.AW(AW)) i_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .idx(idx), .wr_hit(wr_hit), .rd_hit(rd_hit), .bad_acc(bad_acc)
  );

  cfg_reg_store i_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx),
    .wdata(bus_wdata), .perr_set(sram_perr_set), .regs(regs)
  );

  for (genvar k = 0; k < LSEL_N; k++) begin : g_lsel
    assign lsel_flat[k*16 +: 16] = regs[int'(RG_LSEL0) + k][15:0];
  end

  assign cfg1_q = regs[RG_CFG1];
  assign cfg2_q = regs[RG_CFG2];
  assign wp1_q  = regs[RG_WP1];
  assign wp2_q  = regs[RG_WP2];

  line_router #(.NPORT(NPORT)) i_route (
    .pin_lvl(pin_lvl), .sel_flat(lsel_flat), .irq_line(irq_line)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_hit && idx == IDX_W'(i)) rd_val = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad_acc;
      if (bus_sel && !bus_we) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/cfg_bank_checker.sv
module cfg_bank_checker
  import cfg_bank_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NPORT = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_we,
  input logic [AW-1:0]          bus_addr,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic                   bus_err,
  input logic [DATA_W-1:0]      cfg1_q,
  input logic [DATA_W-1:0]      cfg2_q,
  input logic [DATA_W-1:0]      wp1_q,
  input logic [DATA_W-1:0]      wp2_q,
  input logic [LINES*SEL_W-1:0] lsel_flat,
  input logic [NPORT*LINES-1:0] pin_lvl,
  input logic [LINES-1:0]       irq_line
);
  a_r3_bad_offset_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr >= AW'(NREG*4)) |=> bus_err);

  a_r3_unaligned_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0 && bus_err));

  a_r3_err_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  a_r5_fw_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg1_q[0] |=> !cfg1_q[0]);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg2_q[3:0] != 4'h0) |=> ((cfg2_q[3:0] & $past(cfg2_q[3:0])) == $past(cfg2_q[3:0])));

  a_r8_wp1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wp1_q != '0) |=> ((wp1_q & $past(wp1_q)) == $past(wp1_q)));

  a_r8_wp2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wp2_q != '0) |=> ((wp2_q & $past(wp2_q)) == $past(wp2_q)));

  a_r9_sramcs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == AW'(24)) |=> (bus_rdata == '0));

  a_r12_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lsel_flat) && $stable(pin_lvl)) |-> $stable(irq_line));
endmodule

bind sysctl_cfg_bank cfg_bank_checker #(.AW(AW), .NPORT(NPORT)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .wp1_q(wp1_q), .wp2_q(wp2_q),
  .lsel_flat(lsel_flat), .pin_lvl(pin_lvl), .irq_line(irq_line)
);

// File: tb/test_sysctl_cfg_bank.sv
module test_sysctl_cfg_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_we = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         perr = 1'b0;
  logic [127:0] pins = '0;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic [15:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [11];

  always #4 clk = ~clk;

  sysctl_cfg_bank i_sysctl_cfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sram_perr_set(perr),
    .pin_lvl(pins), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_line(irq_line)
  );

  function automatic bit addr_ok(logic [9:0] a);
    return (a[1:0] == 2'b00) && (a[9:2] < 8'd11);
  endfunction

  // Model of each register's write rule, written per offset.
  function automatic logic [31:0] mdl_write(int r, logic [31:0] o, logic [31:0] v);
    case (r)
      0: return {23'b0, v[8], 5'b0, v[2:0]};
      1: return {v[31:26], 2'b00, v[23:16], 7'b0, v[8], 7'b0, o[0] & v[0]};
      2, 3, 4, 5: return {16'b0, v[15:0]};
      6: return 32'h0;
      7: return {23'b0, o[8] & ~v[8], 4'b0, o[3:0] | v[3:0]};
      8, 10: return o | v;
      9: return {24'b0, v[7:0]};
      default: return o;
    endcase
  endfunction

  function automatic logic exp_line(int n);
    logic [3:0] g;
    g = mdl[2 + n/4][(n%4)*4 +: 4];
    return (g < 4'd8) ? pins[int'(g)*16 + n] : 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
    if (we && addr_ok(a)) mdl[a[9:2]] = mdl_write(int'(a[9:2]), mdl[a[9:2]], d);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    logic [31:0] rd; logic er;
    bus_op(1'b1, a, d, rd, er);
  endtask

  task automatic rd_chk(string req, logic [9:0] a, logic [31:0] exp);
    logic [31:0] rd; logic er;
    bus_op(1'b0, a, 32'h0, rd, er);
    chk(req, rd, exp);
  endtask

  task automatic lines_chk(string req);
    #1;
    for (int n = 0; n < 16; n++) chk(req, {31'b0, irq_line[n]}, {31'b0, exp_line(n)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd; logic er;
    void'($urandom(32'd1234));
    for (int i = 0; i < 11; i++) mdl[i] = (i == 1) ? 32'h7C00_0001 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 11; i++) rd_chk("R1 reset", 10'(i*4), mdl[i]);
    lines_chk("R1 port0 select");

    // R4 masks
    wr(10'h000, 32'hFFFF_FFFF); rd_chk("R4 remap mask", 10'h000, 32'h0000_0107);
    wr(10'h024, 32'hFFFF_FFFF); rd_chk("R4 key mask", 10'h024, 32'h0000_00FF);
    wr(10'h00C, 32'hABCD_1234); rd_chk("R4 lsel mask", 10'h00C, 32'h0000_1234);

    // R5 clear-only bit 0
    wr(10'h004, 32'hFFFF_FFFF); rd_chk("R5 cfg1 rw", 10'h004, 32'hFCFF_0101);
    wr(10'h004, 32'h0000_0000); rd_chk("R5 bit0 cleared", 10'h004, 32'h0);
    wr(10'h004, 32'h0000_0001); rd_chk("R5 bit0 not settable", 10'h004, 32'h0);

    // R6 / R7 config2
    wr(10'h01C, 32'h0000_0005); wr(10'h01C, 32'h0000_0000);
    rd_chk("R6 lock sticky", 10'h01C, 32'h0000_0005);
    @(negedge clk); perr = 1'b1; @(negedge clk); perr = 1'b0; mdl[7] |= 32'h100;
    rd_chk("R7 flag set", 10'h01C, 32'h0000_0105);
    wr(10'h01C, 32'h0000_0000); rd_chk("R7 zero no effect", 10'h01C, 32'h0000_0105);
    wr(10'h01C, 32'h0000_0100); rd_chk("R7 w1c", 10'h01C, 32'h0000_0005);
    perr = 1'b1; bus_op(1'b1, 10'h01C, 32'h0000_0100, rd, er); perr = 1'b0;
    mdl[7] |= 32'h100;
    rd_chk("R7 set wins", 10'h01C, 32'h0000_0105);

    // R8 accumulate
    wr(10'h020, 32'h0000_00F0); wr(10'h020, 32'h0000_000F); wr(10'h020, 32'h0);
    rd_chk("R8 wp1 accumulate", 10'h020, 32'h0000_00FF);
    wr(10'h028, 32'h8000_0000); wr(10'h028, 32'h0000_0001);
    rd_chk("R8 wp2 accumulate", 10'h028, 32'h8000_0001);

    // R9 sram control reads zero
    wr(10'h018, 32'hFFFF_FFFF); rd_chk("R9 sramcs zero", 10'h018, 32'h0);

    // R3 undefined and unaligned
    wr(10'h024, 32'h0000_005A);
    bus_op(1'b1, 10'h025, 32'h0000_00FF, rd, er); chk("R3 err unaligned write", {31'b0, er}, 32'h1);
    rd_chk("R3 unaligned write ignored", 10'h024, 32'h0000_005A);
    bus_op(1'b0, 10'h02C, 32'h0, rd, er);
    chk("R3 undefined read zero", rd, 32'h0); chk("R3 err pulse", {31'b0, er}, 32'h1);
    @(negedge clk); chk("R3 err one cycle", {31'b0, bus_err}, 32'h0);
    bus_op(1'b0, 10'h3FC, 32'h0, rd, er); chk("R3 top of window", {31'b0, er}, 32'h1);
    bus_op(1'b0, 10'h028, 32'h0, rd, er); chk("R2 no err valid", {31'b0, er}, 32'h0);
    @(negedge clk); chk("R2 rdata holds", bus_rdata, mdl[10]);

    // R10/R11/R12 routing
    wr(10'h008, 32'h0000_F987); wr(10'h00C, 32'h0000_0000);
    wr(10'h010, 32'h0000_3210); wr(10'h014, 32'h0000_7654);
    for (int it = 0; it < 40; it++) begin
      pins = {$urandom, $urandom, $urandom, $urandom};
      lines_chk("R10 route");
    end
    pins = '1; lines_chk("R11 out of range low");
    wr(10'h008, 32'h0000_0000);
    pins = '0; pins[5*16 + 2] = 1'b1; wr(10'h008, 32'h0000_0500);
    chk("R12 selector switch", {31'b0, irq_line[2]}, 32'h1);
    pins[5*16 + 2] = 1'b0; #1;
    chk("R12 pin follows", {31'b0, irq_line[2]}, 32'h0);

    // Random mixed traffic against the model (R2 R4 R10)
    for (int it = 0; it < 400; it++) begin
      logic [9:0] a; logic we; logic [31:0] d; logic [31:0] exp;
      a  = ($urandom % 5 == 0) ? 10'($urandom) : 10'(($urandom % 11) * 4);
      we = $urandom % 2 == 1;
      d  = $urandom;
      exp = addr_ok(a) ? mdl[a[9:2]] : 32'h0;
      bus_op(we, a, d, rd, er);
      chk("R3 err random", {31'b0, er}, {31'b0, !addr_ok(a)});
      if (!we) chk("R2 random read", rd, exp);
      if (it % 8 == 0) begin
        pins = {$urandom, $urandom, $urandom, $urandom};
        lines_chk("R10 random route");
      end
    end

    finish_run();
  end
endmodule